// File: doc/BRIEF.md
# Serial Receive Holding Stage with Overrun Detection

This block sits behind the deserializer of a synchronous serial port. Each time the serial side finishes assembling a word it pulses a word-complete strobe with the word on a parallel bus. The block captures that word in a staging register. In the next cycle it moves the word into a receive data register that a host reads over a simple read bus. A data-full flag shows that the data register holds an unread word. An overrun flag records that a complete word arrived while the previous one was still unread. The new word is then dropped and the old one is kept.

The host sees the two flags in a 24-bit read-only status word. Clearing an overrun takes two host steps. First the host reads the status word while overrun is set, which arms the clear. Then it reads the data register, which clears the flag. Two interrupt outputs follow the flags, each gated by its own enable input. A parameter selects whether the interrupts are combinational or registered.

Top module: `serial_rx_holding`

## Requirements
- R1: A word-complete strobe sampled at clock edge N places the word in the staging register. At edge N+1, if the data-full flag is clear, the word moves into the data register and data-full sets.
- R2: A host read of the data register (`rd_en`=1, `rd_sel`=0) clears data-full at that edge, unless a staged word is transferred at the same edge.
- R3: If a staged word is ready while data-full is set and no data read happens at that edge, the overrun flag sets. The data register keeps the old word and the new word is discarded.
- R4: Overrun clears when a data read follows a status read (`rd_sel`=1) that saw overrun set, with no other read in between.
- R5: A data read that is not armed by such a status read leaves overrun unchanged.
- R6: If a data read and a staged-word transfer happen at the same edge, the new word is loaded and data-full stays set, with no overrun.
- R7: In the status word, bit 7 is data-full and bit 5 is overrun. All other bits, including bits 23 to 8, read 0. A data read returns the data register zero-extended to 24 bits.
- R8: After reset, data-full, overrun and both interrupt outputs are 0.
- R9: `rx_irq` equals data-full AND `rx_ie`, and `err_irq` equals overrun AND `err_ie`. With the default combinational setting they follow in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_done | input | 1 | Word-complete strobe from the deserializer |
| word_in | input | WORD_W | Assembled word, valid with `word_done` |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | Read target: 0 = data register, 1 = status word |
| rd_data | output | BUS_W | Read data for the selected target |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Overrun interrupt enable |
| rx_irq | output | 1 | Receive data interrupt |
| err_irq | output | 1 | Overrun error interrupt |

## Verification
The hardest case to reach is a data read that lands on the same edge as a staged-word transfer. It takes a strobe placed one cycle earlier, so that the one-cycle staging delay lines the transfer up with the read. The bench issues that strobe, releases it, and raises the data read in the next cycle while data-full is still set. It then checks that the old word came out, the new word was loaded and no overrun appeared. The two-step overrun clear is also driven from both sides: an unarmed data read must leave the flag set, and an armed one must clear it.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
   localparam int unsigned RXH_BUS_W    = 24;
   localparam int unsigned RXH_FULL_BIT = 7;
   localparam int unsigned RXH_OVR_BIT  = 5;
   localparam logic        RXH_SEL_DATA = 1'b0;
   localparam logic        RXH_SEL_STAT = 1'b1;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_STAT = 2'd2
   } rxh_acc_e;
endpackage

// File: rtl/rxh_stage.sv
module rxh_stage #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_done,
   input  logic [WORD_W-1:0] word_in,
   output logic              ready,
   output logic [WORD_W-1:0] stage_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready      <= 1'b0;
         stage_word <= '0;
      end else begin
         ready <= word_done;
         if (word_done) stage_word <= word_in;
      end
   end

   // R1
   stage_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> (ready && stage_word == $past(word_in)));
endmodule

// File: rtl/rxh_hold.sv
module rxh_hold #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready,
   input  logic [WORD_W-1:0] stage_word,
   input  logic              data_rd,
   output logic              full,
   output logic [WORD_W-1:0] data_q
);
   logic load;
   assign load = ready && (!full || data_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full   <= 1'b0;
         data_q <= '0;
      end else begin
         if (load) begin
            full   <= 1'b1;
            data_q <= stage_word;
         end else if (data_rd) begin
            full <= 1'b0;
         end
      end
   end

   // R1
   load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !full) |=> (full && data_q == $past(stage_word)));
   // R2
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !ready) |=> !full);
   // R3
   keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && full && !data_rd) |=> (full && $stable(data_q)));
   // R6
   collide_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && full && data_rd) |=> (full && data_q == $past(stage_word)));
endmodule

// File: rtl/rxh_ovr.sv
module rxh_ovr (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic full,
   input  logic data_rd,
   input  logic stat_rd,
   output logic ovr
);
   logic armed;
   logic ovr_set;
   assign ovr_set = ready && full && !data_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         if (stat_rd)      armed <= ovr;
         else if (data_rd) armed <= 1'b0;
         if (ovr_set)                ovr <= 1'b1;
         else if (data_rd && armed)  ovr <= 1'b0;
      end
   end

   // R3
   ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && full && !data_rd) |=> ovr);
   // R4
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && armed) |=> !ovr);
   // R5
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !armed) |=> (ovr == $past(ovr)));
   // R4
   arm_needs_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ovr) |=> !armed);
endmodule

// File: rtl/serial_rx_holding.sv
module serial_rx_holding #(
   parameter int unsigned WORD_W   = 24,
   parameter int unsigned BUS_W    = rxh_pkg::RXH_BUS_W,
   parameter int unsigned FULL_BIT = rxh_pkg::RXH_FULL_BIT,
   parameter int unsigned OVR_BIT  = rxh_pkg::RXH_OVR_BIT,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_done,
   input  logic [WORD_W-1:0] word_in,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [BUS_W-1:0]  rd_data,
   input  logic              rx_ie,
   input  logic              err_ie,
   output logic              rx_irq,
   output logic              err_irq
);
   import rxh_pkg::*;

   localparam int unsigned PAD_W = BUS_W - WORD_W;

   if (WORD_W == 0 || WORD_W > BUS_W) begin : g_bad_width
      $error("WORD_W must be between 1 and BUS_W");
   end
   if (FULL_BIT >= BUS_W || OVR_BIT >= BUS_W || FULL_BIT == OVR_BIT) begin : g_bad_bits
      $error("status bit positions must be distinct and inside BUS_W");
   end

   rxh_acc_e acc;
   always_comb begin
      if (!rd_en)                    acc = ACC_NONE;
      else if (rd_sel == RXH_SEL_STAT) acc = ACC_STAT;
      else                           acc = ACC_DATA;
   end

   logic              data_rd, stat_rd;
   logic              ready, full, ovr;
   logic [WORD_W-1:0] stage_word, data_q;
   logic [BUS_W-1:0]  status;
   logic [BUS_W-1:0]  data_ext;

   assign data_rd = (acc == ACC_DATA);
   assign stat_rd = (acc == ACC_STAT);

   rxh_stage #(.WORD_W(WORD_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_in(word_in),
      .ready(ready), .stage_word(stage_word));

   rxh_hold #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .ready(ready), .stage_word(stage_word),
      .data_rd(data_rd), .full(full), .data_q(data_q));

   rxh_ovr u_ovr (
      .clk(clk), .rst_n(rst_n), .ready(ready), .full(full),
      .data_rd(data_rd), .stat_rd(stat_rd), .ovr(ovr));

   always_comb begin
      status           = '0;
      status[FULL_BIT] = full;
      status[OVR_BIT]  = ovr;
   end

   if (PAD_W > 0) begin : g_pad
      assign data_ext = {{PAD_W{1'b0}}, data_q};
   end else begin : g_nopad
      assign data_ext = data_q;
   end

   assign rd_data = (rd_sel == RXH_SEL_STAT) ? status : data_ext;

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_irq  <= 1'b0;
            err_irq <= 1'b0;
         end else begin
            rx_irq  <= full && rx_ie;
            err_irq <= ovr && err_ie;
         end
      end
      // R9
      irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (rx_irq == $past(full && rx_ie) && err_irq == $past(ovr && err_ie)));
   end else begin : g_irq_comb
      assign rx_irq  = full && rx_ie;
      assign err_irq = ovr && err_ie;
   end

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!u_hold.full || rst_n));
   // R3
   ovr_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> full);
endmodule

// File: tb/serial_rx_holding_tb.sv
module serial_rx_holding_tb;
   localparam int W = 24;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          word_done = 1'b0;
   logic [W-1:0]  word_in = '0;
   logic          rd_en = 1'b0;
   logic          rd_sel = 1'b0;
   logic [23:0]   rd_data;
   logic          rx_ie = 1'b0, err_ie = 1'b0;
   logic          rx_irq, err_irq;

   int n_chk = 0, n_bad = 0;
   logic [W-1:0] exp_q[$];

   always #2 clk = ~clk;

   serial_rx_holding u_dut (
      .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_in(word_in),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .rx_ie(rx_ie), .err_ie(err_ie), .rx_irq(rx_irq), .err_irq(err_irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: one strobe; push expected word when it will be accepted
   task automatic send(input logic [W-1:0] w, input bit accept);
      @(negedge clk);
      word_done = 1'b1; word_in = w;
      @(negedge clk);
      word_done = 1'b0;
      if (accept) exp_q.push_back(w);
      @(negedge clk);
   endtask

   // monitor side: a data read pops the scoreboard and compares
   task automatic read_data(input string req, input bit compare);
      logic [W-1:0] e;
      rd_en = 1'b1; rd_sel = 1'b0;
      #1;
      if (compare) begin
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
         chk(req, {8'h0, rd_data}, {8'h0, e});
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic read_stat(input string req, input logic [23:0] exp);
      rd_en = 1'b1; rd_sel = 1'b1;
      #1;
      chk(req, {8'h0, rd_data}, {8'h0, exp});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek_stat(input string req, input logic [23:0] exp);
      rd_sel = 1'b1;
      #1;
      chk(req, {8'h0, rd_data}, {8'h0, exp});
      rd_sel = 1'b0;
   endtask

   initial begin
      fork
         begin
            repeat (5000) @(posedge clk);
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      // R8 reset state
      peek_stat("R8 status", 24'h0);
      chk("R8 irqs", {30'h0, rx_irq, err_irq}, 32'h0);
      rst_n = 1'b1;
      rx_ie = 1'b1; err_ie = 1'b1;
      @(negedge clk);

      // R1 / R7 / R9
      send(24'hA5A5A5, 1'b1);
      peek_stat("R1 R7 full bit7", 24'h000080);
      chk("R9 rx_irq", {31'h0, rx_irq}, 32'h1);
      read_data("R1 data", 1'b1);
      peek_stat("R2 full cleared", 24'h0);
      chk("R9 rx_irq low", {31'h0, rx_irq}, 32'h0);

      // R3 overrun
      send(24'h123456, 1'b1);
      send(24'hFEDCBA, 1'b0);
      peek_stat("R3 R7 ovr bit5", 24'h0000A0);
      chk("R9 err_irq", {31'h0, err_irq}, 32'h1);
      // R5: unarmed read leaves overrun, returns old word (R3)
      read_data("R3 old word kept", 1'b1);
      peek_stat("R5 ovr stays", 24'h000020);
      read_data("R5 second read", 1'b0);
      peek_stat("R5 ovr still", 24'h000020);
      // R4 two-step clear
      read_stat("R4 status read", 24'h000020);
      read_data("R4 data read", 1'b0);
      peek_stat("R4 ovr cleared", 24'h0);
      chk("R9 err_irq low", {31'h0, err_irq}, 32'h0);

      // R6 collision: read and transfer at same edge
      send(24'h0000D1, 1'b1);
      @(negedge clk);
      word_done = 1'b1; word_in = 24'h0000E2;
      @(negedge clk);
      word_done = 1'b0;
      exp_q.push_back(24'h0000E2);
      read_data("R6 old word out", 1'b1);
      peek_stat("R6 full stays no ovr", 24'h000080);
      read_data("R6 new word loaded", 1'b1);

      // R9 enables gate
      rx_ie = 1'b0; err_ie = 1'b0;
      send(24'h000011, 1'b1);
      send(24'h000022, 1'b0);
      peek_stat("R9 flags set", 24'h0000A0);
      chk("R9 gated", {30'h0, rx_irq, err_irq}, 32'h0);
      read_data("R3 old kept again", 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule